// File: doc/BRIEF.md
# Key-Guarded Sequence Table Register File

This block holds the instruction table that a serial-flash sequencer walks through. The table has 64 words of 32 bits. A simple write strobe (valid, word address, data) reaches three targets: a key register, a lock-control register and the table words. The table sits at consecutive word addresses from a fixed base. A combinational read port lets the sequencer fetch any word by its index.

Software changes the table in a fixed order. It writes the key and then the unlock command. It then writes the table words, and a clear to all zeros is a normal first pass. Last, it writes the key again, followed by the lock command. While the file is locked, table writes are dropped. A lock or unlock command counts only when the write just before it on the bus put the magic value 32'h5AF05AF0 into the key register. Idle cycles between the two writes do not matter. Any other write between them cancels the key.

Top module: `seqtab_regfile`

Default word map: key register at address 8'h00, lock-control register at 8'h01, table words at 8'h40 + index for index 0..63. All other addresses are unmapped.

## Requirements
- R1: After reset, every table word reads 0 and `lock_state` is 0 (unlocked).
- R2: While unlocked, a write to address 8'h40+i stores the data in word i. The data can be read on `rd_word` with `rd_idx`=i from the cycle after the write.
- R3: While locked, a table write is dropped, and every table word keeps its contents.
- R4: A lock-control write of 32'd1, when the write just before it was 32'h5AF05AF0 to the key register, sets `lock_state` to 1 from the next cycle.
- R5: A lock-control write of 32'd2, under the same key condition, sets `lock_state` to 0 from the next cycle.
- R6: A lock-control write has no effect when the write just before it was not a correct key write. This covers no key at all, a key register write with any other value, and a key followed by some other write.
- R7: A lock-control write whose value is neither 1 nor 2 leaves `lock_state` unchanged, but it still uses up the armed key. A command that follows it right away is ignored.
- R8: A write to an unmapped address changes no table word and does not change `lock_state`. It also cancels an armed key.
- R9: Cycles with `wr_valid` low between the key write and the command write do not cancel the armed key.
- R10: Writing 0 to every table word while unlocked leaves the whole table reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 6 | Table index for the read port |
| rd_word | output | 32 | Table word at `rd_idx`, combinational |
| lock_state | output | 1 | 1 when table writes are blocked |

## Verification
The hardest states to reach are the ones where the armed key is in play while another write happens. This happens when a key write is followed by a table write, an unmapped write, a wrong key value or an unknown command before the real command arrives. The stimulus places each kind of write between a key and a command, and also places idle gaps there. It then reads `lock_state` and sweeps the full table, so that a cancelled arm or a leaked write shows up. Whole-table sweeps with computed patterns also cover the write path through every index, both locked and unlocked.

// File: rtl/seqtab_pkg.sv
package seqtab_pkg;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_KEY  = 2'd1,
    RG_CTRL = 2'd2,
    RG_TBL  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    CMD_OTHER  = 2'd0,
    CMD_LOCK   = 2'd1,
    CMD_UNLOCK = 2'd2
  } lock_cmd_e;

  localparam logic [31:0] KEY_MAGIC  = 32'h5AF0_5AF0;
  localparam logic [31:0] CODE_LOCK   = 32'd1;
  localparam logic [31:0] CODE_UNLOCK = 32'd2;

  function automatic lock_cmd_e classify_cmd(input logic [31:0] d);
    if (d == CODE_LOCK)        return CMD_LOCK;
    else if (d == CODE_UNLOCK) return CMD_UNLOCK;
    else                       return CMD_OTHER;
  endfunction

endpackage

// File: rtl/seqtab_decode.sv
module seqtab_decode
  import seqtab_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 64,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] TBL_BASE  = 8'h40,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [ADDR_W:0] DEPTH_A = DEPTH[ADDR_W:0];

  logic [ADDR_W-1:0] offset;

  function automatic region_e map_region(input logic [ADDR_W-1:0] a,
                                         input logic [ADDR_W-1:0] off);
    if (a == KEY_ADDR)                  return RG_KEY;
    else if (a == CTRL_ADDR)            return RG_CTRL;
    else if ({1'b0, off} < DEPTH_A)     return RG_TBL;
    else                                return RG_NONE;
  endfunction

  always_comb begin
    offset   = addr_i - TBL_BASE;
    region_o = map_region(addr_i, offset);
    idx_o    = offset[IDX_W-1:0];
  end

endmodule

// File: rtl/seqtab_guard.sv
module seqtab_guard
  import seqtab_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  region_e           region_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              locked_o
);

  logic      armed_q, armed_d;
  logic      locked_q, locked_d;
  logic      key_ok;
  logic      ctrl_wr;
  lock_cmd_e cmd;
  logic      lock_evt;
  logic      unlock_evt;

  always_comb begin
    key_ok     = wr_valid_i && (region_i == RG_KEY) && (data_i == KEY_MAGIC);
    ctrl_wr    = wr_valid_i && (region_i == RG_CTRL);
    cmd        = classify_cmd(data_i);
    lock_evt   = ctrl_wr && armed_q && (cmd == CMD_LOCK);
    unlock_evt = ctrl_wr && armed_q && (cmd == CMD_UNLOCK);
    armed_d    = wr_valid_i ? key_ok : armed_q;
    if (lock_evt)        locked_d = 1'b1;
    else if (unlock_evt) locked_d = 1'b0;
    else                 locked_d = locked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o = locked_q;

  // R4
  lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> locked_q);

  // R5
  unlock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_evt |=> !locked_q);

  // R6
  arm_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> $stable(locked_q));

  // R7
  arm_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !armed_q);

  // R9
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !wr_valid_i) |=> armed_q);

endmodule

// File: rtl/seqtab_store.sv
module seqtab_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit_i,
  input  logic              lock_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DEPTH-1:0][DATA_W-1:0] mem;
  logic                         wr_open;

  assign wr_open = wr_hit_i && !lock_i;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[gi] <= '0;
      else if (wr_open && (wr_idx_i == IDX_W'(gi)))
        mem[gi] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_idx_i];

  // R3
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_i && lock_i) |=> $stable(mem));

  // R8
  nonhit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit_i |=> $stable(mem));

  // R2
  word_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_open |=> (mem[$past(wr_idx_i)] == $past(wr_data_i)));

endmodule

// File: rtl/seqtab_regfile.sv
module seqtab_regfile
  import seqtab_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] TBL_BASE  = 8'h40,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic              lock_state
);

  region_e          region;
  logic [IDX_W-1:0] wr_idx;
  logic             tbl_hit;
  logic             locked;

  seqtab_decode #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH),
    .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR), .TBL_BASE(TBL_BASE)
  ) u_decode (
    .addr_i  (wr_addr),
    .region_o(region),
    .idx_o   (wr_idx)
  );

  seqtab_guard #(.DATA_W(DATA_W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid_i(wr_valid),
    .region_i  (region),
    .data_i    (wr_data),
    .locked_o  (locked)
  );

  assign tbl_hit = wr_valid && (region == RG_TBL);

  seqtab_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit_i (tbl_hit),
    .lock_i   (locked),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_word)
  );

  assign lock_state = locked;

  // R8
  unmapped_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && region == RG_NONE) |=> $stable(lock_state));

endmodule

// File: tb/seqtab_regfile_tb.sv
`timescale 1ns/1ps
module seqtab_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_word;
  logic        lock_state;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_tbl [64];

  localparam logic [7:0]  A_KEY  = 8'h00;
  localparam logic [7:0]  A_CTRL = 8'h01;
  localparam logic [7:0]  A_BASE = 8'h40;
  localparam logic [31:0] MAGIC  = 32'h5AF05AF0;

  always #5 clk = ~clk;

  seqtab_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_word(rd_word),
    .lock_state(lock_state)
  );

  function automatic logic [31:0] pat(input int i, input logic [31:0] seed);
    return (32'h9E3779B9 * (i + 1)) ^ seed;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk_lock(input logic e, input string req);
    chk(lock_state === e, req, {31'd0, lock_state}, {31'd0, e});
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 64; i++) begin
      rd_idx = 6'(i);
      #1;
      chk(rd_word === exp_tbl[i], req, rd_word, exp_tbl[i]);
    end
  endtask

  task automatic fill(input logic [31:0] seed, input bit applies);
    for (int i = 0; i < 64; i++) begin
      wr(A_BASE + 8'(i), pat(i, seed));
      if (applies) exp_tbl[i] = pat(i, seed);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_tbl[i] = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents and unlocked
    chk_lock(1'b0, "R1");
    sweep("R1");

    // R2: fill unlocked
    fill(32'h0000_0000, 1'b1);
    sweep("R2");
    fill(32'hC3A5_0F17, 1'b1);
    sweep("R2");

    // R4: key then lock
    wr(A_KEY, MAGIC); wr(A_CTRL, 32'd1);
    chk_lock(1'b1, "R4");

    // R3: locked writes dropped
    fill(32'hFFFF_0000, 1'b0);
    sweep("R3");

    // R6: command with no key
    wr(A_CTRL, 32'd2);
    chk_lock(1'b1, "R6");
    // R6: wrong key value
    wr(A_KEY, MAGIC ^ 32'h1); wr(A_CTRL, 32'd2);
    chk_lock(1'b1, "R6");
    // R6: key, then a table write, then command
    wr(A_KEY, MAGIC); wr(A_BASE + 8'd5, 32'hDEAD_BEEF); wr(A_CTRL, 32'd2);
    chk_lock(1'b1, "R6");
    sweep("R3");
    // R6: key, key register rewritten with another value, then command
    wr(A_KEY, MAGIC); wr(A_KEY, 32'h0); wr(A_CTRL, 32'd2);
    chk_lock(1'b1, "R6");

    // R9 and R5: idle gap between key and unlock
    wr(A_KEY, MAGIC); idle(5); wr(A_CTRL, 32'd2);
    chk_lock(1'b0, "R9");
    chk_lock(1'b0, "R5");

    // R7: unknown command uses up the key
    wr(A_KEY, MAGIC); wr(A_CTRL, 32'd3);
    chk_lock(1'b0, "R7");
    wr(A_CTRL, 32'd1);
    chk_lock(1'b0, "R7");
    wr(A_KEY, MAGIC); wr(A_CTRL, 32'd0);
    chk_lock(1'b0, "R7");

    // R8: every unmapped address leaves table and lock alone
    for (int a = 2; a < 256; a++) begin
      if (a >= 8'h40 && a < 8'h80) continue;
      wr(8'(a), pat(a, 32'h1234_5678));
    end
    sweep("R8");
    chk_lock(1'b0, "R8");
    // R8: unmapped write cancels armed key
    wr(A_KEY, MAGIC); wr(8'hA0, 32'h1); wr(A_CTRL, 32'd1);
    chk_lock(1'b0, "R8");

    // R4 then R5 with a locked window in between
    wr(A_KEY, MAGIC); wr(A_CTRL, 32'd1);
    chk_lock(1'b1, "R4");
    wr(A_BASE + 8'd63, 32'h0BAD_0BAD);
    sweep("R3");
    wr(A_KEY, MAGIC); wr(A_CTRL, 32'd2);
    chk_lock(1'b0, "R5");

    // R10: clear by zero writes
    for (int i = 0; i < 64; i++) begin
      wr(A_BASE + 8'(i), 32'h0);
      exp_tbl[i] = '0;
    end
    sweep("R10");

    // R2: last index then first index boundary
    wr(A_BASE + 8'd63, 32'hA5A5_5A5A); exp_tbl[63] = 32'hA5A5_5A5A;
    wr(A_BASE, 32'h0102_0304); exp_tbl[0] = 32'h0102_0304;
    sweep("R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule